// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. The line idles high, and each frame begins with a low start bit. After the start bit come seven or eight data bits, least significant bit first, then an optional parity bit and one or two stop bits. The receive timebase is a one-cycle enable pulse, `rxTick`, made elsewhere in the `clk` domain. There is one pulse per rising edge of the receive clock. The block uses one, sixteen or sixty-four of these pulses per bit, depending on the divide select.

The serial input first passes through a flop synchronizer. In the oversampled modes, a low level seen on a tick starts a count to half a bit period. If the line has gone high again by then, the start is discarded and the receiver returns to idle. Otherwise each following bit is sampled once, at its middle. In the divide-by-one mode, every tick samples one bit, so the receive clock must already be aligned to the data.

A character is complete when its first stop bit is sampled. The character is then held on `rxData` together with its framing-error and parity-error flags, and `rxDone` pulses for one cycle. The held character stays until the consumer pulses `rxTake`. If a later character completes before that, it is dropped and `overrun` rises. The receiver stays in step with the line through an overrun, so following frames are still received correctly.

Top module: `serialRx`

## Requirements
- R1: While `rstN` is low, or while `divSel` is 2'b11, the receiver is held idle and `rxFull`, `overrun` and `rxDone` are low.
- R2: With `fmtSel[2]`=1 (eight data bits), the eight bits after the start bit are assembled least significant bit first. When the first stop bit is sampled, the character appears on `rxData`, `rxFull` rises and `rxDone` is high for exactly one cycle.
- R3: With `fmtSel[2]`=0 (seven data bits), only seven data bits are taken and `rxData[7]` is delivered as 0.
- R4: Parity is present when `fmtSel[2]`=0 or `fmtSel[1]`=1. `fmtSel[0]`=1 selects odd parity and 0 selects even parity. `parityErr` is set when the number of ones across the data and parity bits is not odd (odd parity) or not even (even parity).
- R5: For the no-parity codes 3'b100 and 3'b101, `parityErr` is always 0.
- R6: `frameErr` is set when the first stop bit samples low. Two stop bits are used by codes 3'b000, 3'b001 and 3'b100, but the second stop bit is never checked.
- R7: While `rxFull` is high and `rxTake` is not pulsed, `rxData`, `frameErr` and `parityErr` do not change.
- R8: If a character completes while `rxFull` is high and `rxTake` is not pulsed, that character is dropped. `overrun` rises, the held character is kept, and `rxDone` does not pulse. An `rxTake` pulse clears both `rxFull` and `overrun`.
- R9: After an overrun, the next frame is received correctly.
- R10: `divSel` 2'b00 samples one bit per tick. 2'b01 uses 16 ticks per bit and 2'b10 uses 64 ticks per bit, with each bit sampled at its middle.
- R11: In the 16 and 64 modes, a low pulse shorter than half a bit period is a false start. No character is produced, and the next proper frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxTick | input | 1 | One-cycle enable per receive-clock rising edge |
| divSel | input | 2 | Ticks per bit: 00=1, 01=16, 10=64, 11=held in clear |
| fmtSel | input | 3 | Frame format: [2] eight data bits, [1] with [2] adds parity, [0] odd parity |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| rxTake | input | 1 | Pulse marking the held character as consumed |
| rxData | output | 8 | Held character |
| rxFull | output | 1 | A character is held and not yet taken |
| rxDone | output | 1 | One-cycle strobe when a character is loaded |
| frameErr | output | 1 | First stop bit of the held character was low |
| parityErr | output | 1 | Parity mismatch on the held character |
| overrun | output | 1 | A character was lost while the previous one was held |

## Verification
The hardest case to reach is overrun. Reaching it requires a second character to complete while the first is still held, and then proof that the receiver has stayed aligned to the line. The bench sends two complete frames without pulsing `rxTake`. It checks that the first character is still held with `overrun` set and only one `rxDone` strobe counted. It then takes the character and sends a third frame, which must arrive intact. False starts are made by holding the line low for a quarter of a bit in the 16-tick mode, followed at once by a valid frame.

// File: rtl/rxPkg.sv
package rxPkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic clearFrame;
    logic dataBit;
    logic parityBit;
    logic stopBit;
  } rxStrobes_t;

  function automatic logic [IDX_W:0] dataBitsOf(input logic [2:0] fmt);
    return fmt[2] ? (IDX_W+1)'(DATA_W) : (IDX_W+1)'(DATA_W - 1);
  endfunction

  function automatic logic hasParityOf(input logic [2:0] fmt);
    return !fmt[2] || fmt[1];
  endfunction

  function automatic logic oddParityOf(input logic [2:0] fmt);
    return fmt[0];
  endfunction

endpackage

// File: rtl/rxSync.sv
module rxSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= asyncIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rxCtrl.sv
module rxCtrl import rxPkg::*; #(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64,
  localparam int CNT_W   = $clog2(DIV_SLOW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterClr,
  input  logic             tick,
  input  logic [1:0]       divSel,
  input  logic [2:0]       fmtSel,
  input  logic             lineIn,
  output rxStrobes_t       strb,
  output logic [IDX_W-1:0] bitIdx
);
  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   divN;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] halfLast;
  logic [IDX_W-1:0] lastIdx;
  logic             slowMode;
  logic             midHit;

  always_comb begin
    case (divSel)
      2'b01:   divN = (CNT_W+1)'(DIV_MID);
      2'b10:   divN = (CNT_W+1)'(DIV_SLOW);
      default: divN = (CNT_W+1)'(1);
    endcase
  end

  assign slowMode = divSel[0] ^ divSel[1];
  assign lastCnt  = CNT_W'(divN - 1'b1);
  assign halfLast = CNT_W'((divN >> 1) - 1'b1);
  assign lastIdx  = IDX_W'(dataBitsOf(fmtSel) - 1'b1);
  assign midHit   = tick && (cnt == lastCnt);

  always_comb begin
    strb = '0;
    if (!masterClr) begin
      case (state)
        ST_IDLE:   strb.clearFrame = tick && !lineIn && !slowMode;
        ST_START:  strb.clearFrame = tick && (cnt == halfLast) && !lineIn;
        ST_DATA:   strb.dataBit    = midHit;
        ST_PARITY: strb.parityBit  = midHit;
        ST_STOP:   strb.stopBit    = midHit;
        default:   strb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (masterClr) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tick && !lineIn) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= slowMode ? ST_START : ST_DATA;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == halfLast) begin
              cnt    <= '0;
              bitIdx <= '0;
              state  <= lineIn ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA, ST_PARITY, ST_STOP: begin
          if (tick) cnt <= midHit ? '0 : cnt + 1'b1;
          if (strb.dataBit) begin
            if (bitIdx == lastIdx)
              state <= hasParityOf(fmtSel) ? ST_PARITY : ST_STOP;
            else
              bitIdx <= bitIdx + 1'b1;
          end
          if (strb.parityBit) state <= ST_STOP;
          if (strb.stopBit)   state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxDatapath.sv
module rxDatapath import rxPkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterClr,
  input  rxStrobes_t        strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [2:0]        fmtSel,
  input  logic              lineIn,
  input  logic              rxTake,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxDone,
  output logic              frameErr,
  output logic              parityErr,
  output logic              overrun
);
  logic [DATA_W-1:0] frameBuf;
  logic              onesAcc;
  logic              parBit;
  logic              lostChar;
  logic [DATA_W-1:0] loadData;

  assign lostChar = rxFull && !rxTake;
  assign loadData = fmtSel[2] ? frameBuf : {1'b0, frameBuf[DATA_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameBuf <= '0;
      onesAcc  <= 1'b0;
      parBit   <= 1'b0;
    end else if (masterClr || strb.clearFrame) begin
      frameBuf <= '0;
      onesAcc  <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (strb.dataBit) begin
        frameBuf[bitIdx] <= lineIn;
        onesAcc          <= onesAcc ^ lineIn;
      end
      if (strb.parityBit) parBit <= lineIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxFull    <= 1'b0;
      rxDone    <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      overrun   <= 1'b0;
    end else if (masterClr) begin
      rxData    <= '0;
      rxFull    <= 1'b0;
      rxDone    <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (rxTake) begin
        rxFull  <= 1'b0;
        overrun <= 1'b0;
      end
      if (strb.stopBit) begin
        if (lostChar) begin
          overrun <= 1'b1;
        end else begin
          rxData    <= loadData;
          frameErr  <= !lineIn;
          parityErr <= hasParityOf(fmtSel) &&
                       ((onesAcc ^ parBit) != oddParityOf(fmtSel));
          rxFull    <= 1'b1;
          rxDone    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serialRx.sv
module serialRx import rxPkg::*; #(
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxTick,
  input  logic [1:0] divSel,
  input  logic [2:0] fmtSel,
  input  logic       serialIn,
  input  logic       rxTake,
  output logic [7:0] rxData,
  output logic       rxFull,
  output logic       rxDone,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrun
);
  logic             lineSync;
  logic             masterClr;
  rxStrobes_t       strb;
  logic [IDX_W-1:0] bitIdx;

  assign masterClr = (divSel == 2'b11);

  rxSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(serialIn), .syncOut(lineSync)
  );

  rxCtrl #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) uCtrl (
    .clk(clk), .rstN(rstN), .masterClr(masterClr), .tick(rxTick),
    .divSel(divSel), .fmtSel(fmtSel), .lineIn(lineSync),
    .strb(strb), .bitIdx(bitIdx)
  );

  rxDatapath uPath (
    .clk(clk), .rstN(rstN), .masterClr(masterClr), .strb(strb),
    .bitIdx(bitIdx), .fmtSel(fmtSel), .lineIn(lineSync), .rxTake(rxTake),
    .rxData(rxData), .rxFull(rxFull), .rxDone(rxDone),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun)
  );
endmodule

// File: rtl/serialRxChk.sv
module serialRxChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] divSel,
  input logic [2:0] fmtSel,
  input logic       rxTake,
  input logic [7:0] rxData,
  input logic       rxFull,
  input logic       rxDone,
  input logic       frameErr,
  input logic       parityErr,
  input logic       overrun
);
  assert_master_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    divSel == 2'b11 |=> !rxFull && !overrun && !rxDone);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> rxFull ##1 !rxDone);

  assert_msb_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !fmtSel[2] |-> !rxData[7]);

  assert_no_parity_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && fmtSel[2:1] == 2'b10 |-> !parityErr);

  assert_hold_char_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && !rxTake && divSel != 2'b11 |=>
      $stable(rxData) && $stable(frameErr) && $stable(parityErr));

  assert_overrun_when_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull) && !rxDone);
endmodule

bind serialRx serialRxChk uChk (
  .clk(clk), .rstN(rstN), .divSel(divSel), .fmtSel(fmtSel), .rxTake(rxTake),
  .rxData(rxData), .rxFull(rxFull), .rxDone(rxDone), .frameErr(frameErr),
  .parityErr(parityErr), .overrun(overrun)
);

// File: tb/serialRx_test.sv
module serialRx_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxTick = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic [2:0] fmtSel = 3'b101;
  logic       serialIn = 1'b1;
  logic       rxTake = 1'b0;
  logic [7:0] rxData;
  logic       rxFull, rxDone, frameErr, parityErr, overrun;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serialRx uut (
    .clk(clk), .rstN(rstN), .rxTick(rxTick), .divSel(divSel), .fmtSel(fmtSel),
    .serialIn(serialIn), .rxTake(rxTake), .rxData(rxData), .rxFull(rxFull),
    .rxDone(rxDone), .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun)
  );

  always @(negedge clk) if (rxDone) doneCnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tickOnce();
    repeat (3) @(negedge clk);
    rxTick = 1'b1;
    @(negedge clk);
    rxTick = 1'b0;
  endtask

  task automatic sendBit(input logic v, input int n);
    serialIn = v;
    for (int i = 0; i < n; i++) tickOnce();
  endtask

  function automatic int ticksPerBit(input logic [1:0] d);
    return (d == 2'b01) ? 16 : (d == 2'b10) ? 64 : 1;
  endfunction

  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input logic stopVal);
    int n = ticksPerBit(divSel);
    int nd = fmtSel[2] ? 8 : 7;
    bit hp = !fmtSel[2] || fmtSel[1];
    bit twoStop = (fmtSel == 3'b000) || (fmtSel == 3'b001) || (fmtSel == 3'b100);
    logic ones = 1'b0;
    sendBit(1'b0, n);
    for (int i = 0; i < nd; i++) begin
      sendBit(d[i], n);
      ones = ones ^ d[i];
    end
    if (hp) sendBit((fmtSel[0] ? ~ones : ones) ^ flipPar, n);
    sendBit(stopVal, n);
    if (twoStop) sendBit(1'b1, n);
    sendBit(1'b1, n);
  endtask

  task automatic take();
    @(negedge clk);
    rxTake = 1'b1;
    @(negedge clk);
    rxTake = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 rxFull after reset", rxFull, 0);
    check("R1 overrun after reset", overrun, 0);
    check("R1 rxDone after reset", rxDone, 0);
  endtask

  task automatic testEightNoParity();
    int d0;
    divSel = 2'b00; fmtSel = 3'b101;
    d0 = doneCnt;
    sendFrame(8'hA5, 1'b0, 1'b1);
    check("R2 R10 data 8N1 div1", rxData, 8'hA5);
    check("R2 rxFull", rxFull, 1);
    check("R2 one done strobe", doneCnt - d0, 1);
    check("R5 parityErr 8N1", parityErr, 0);
    check("R6 frameErr clean", frameErr, 0);
    take();
    check("R8 take clears rxFull", rxFull, 0);
    fmtSel = 3'b100;
    sendFrame(8'h3C, 1'b0, 1'b1);
    check("R2 data 8N2", rxData, 8'h3C);
    check("R5 parityErr 8N2", parityErr, 0);
    take();
  endtask

  task automatic testSevenBit();
    divSel = 2'b01; fmtSel = 3'b010;
    sendFrame(8'hD5, 1'b0, 1'b1);
    check("R3 R10 7E1 msb zero", rxData, 8'h55);
    check("R4 7E1 good parity", parityErr, 0);
    take();
    fmtSel = 3'b001;
    sendFrame(8'h2B, 1'b1, 1'b1);
    check("R3 7O2 data", rxData, 8'h2B);
    check("R4 7O2 bad parity", parityErr, 1);
    take();
  endtask

  task automatic testEightParity();
    divSel = 2'b10; fmtSel = 3'b111;
    sendFrame(8'h81, 1'b0, 1'b1);
    check("R10 8O1 div64 data", rxData, 8'h81);
    check("R4 8O1 good parity", parityErr, 0);
    take();
    divSel = 2'b01; fmtSel = 3'b110;
    sendFrame(8'h07, 1'b1, 1'b1);
    check("R4 8E1 bad parity", parityErr, 1);
    take();
  endtask

  task automatic testFraming();
    divSel = 2'b01; fmtSel = 3'b101;
    sendFrame(8'h5A, 1'b0, 1'b0);
    check("R6 frameErr set", frameErr, 1);
    check("R6 data with frame error", rxData, 8'h5A);
    repeat (20) @(negedge clk);
    check("R7 frameErr held", frameErr, 1);
    take();
    sendFrame(8'h11, 1'b0, 1'b1);
    check("R6 frameErr clears", frameErr, 0);
    take();
  endtask

  task automatic testOverrun();
    int d0;
    divSel = 2'b00; fmtSel = 3'b110;
    d0 = doneCnt;
    sendFrame(8'hC3, 1'b0, 1'b1);
    check("R8 no overrun first", overrun, 0);
    sendFrame(8'h99, 1'b0, 1'b1);
    check("R8 overrun set", overrun, 1);
    check("R8 R7 first char kept", rxData, 8'hC3);
    check("R8 no strobe for lost char", doneCnt - d0, 1);
    take();
    check("R8 overrun cleared", overrun, 0);
    check("R8 rxFull cleared", rxFull, 0);
    sendFrame(8'h6E, 1'b0, 1'b1);
    check("R9 data after overrun", rxData, 8'h6E);
    check("R9 parity after overrun", parityErr, 0);
    take();
  endtask

  task automatic testFalseStart();
    int d0;
    divSel = 2'b01; fmtSel = 3'b101;
    d0 = doneCnt;
    sendBit(1'b0, 4);
    sendBit(1'b1, 16);
    check("R11 no char from glitch", rxFull, 0);
    check("R11 no strobe from glitch", doneCnt - d0, 0);
    sendFrame(8'hE7, 1'b0, 1'b1);
    check("R11 frame after glitch", rxData, 8'hE7);
    take();
  endtask

  task automatic testMasterClear();
    divSel = 2'b00; fmtSel = 3'b101;
    sendFrame(8'h42, 1'b0, 1'b1);
    check("R1 held before clear", rxFull, 1);
    divSel = 2'b11;
    repeat (3) @(negedge clk);
    check("R1 clear drops rxFull", rxFull, 0);
    check("R1 clear drops overrun", overrun, 0);
    divSel = 2'b00;
    sendFrame(8'h24, 1'b0, 1'b1);
    check("R1 receive after clear", rxData, 8'h24);
    take();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testEightNoParity();
    testSevenBit();
    testEightParity();
    testFraming();
    testOverrun();
    testFalseStart();
    testMasterClear();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule